// File: doc/BRIEF.md
# Programmable Event Counter Bank with Sticky Overflow Reporting

This block holds a set of 64-bit event counters for an address-translation unit. Each counter has a selector that names the event it counts. An event pulse arrives with an event code and a qualification vector, one bit per counter, produced by an upstream requester filter. A counter advances by one when four things hold: its inhibit bit is clear, its qualification bit is set, its selector names the incoming code, and that code is non-zero.

A counter at all-ones wraps to zero on its next count. The first wrap after its status flag was cleared sets that flag in the shared overflow-status vector, latches an overflow mark in the counter's selector, and produces a one-cycle interrupt pulse. Software clears the flag by rewriting the selector with the mark cleared.

Bit 0 of the status vector belongs to a cycle counter that lives elsewhere, so counter i owns status bit i+1 and inhibit bit i+1. Software writes counters and selectors through a single write port. It reads them back through a registered read port.

Top module: `ecb_bank`

## Requirements
- R1: After reset every counter, every selector, the status vector and the interrupt are zero. Status bit 0 always reads zero.
- R2: On a cycle with `evt_valid` and `cap_en` high, counter i adds one when `inhibit[i+1]` is 0, `evt_qual[i]` is 1, and its stored event code is non-zero and equal to `evt_id`. No other counter changes.
- R3: A counting counter at all-ones becomes zero. If `ovf_status[i+1]` was 0, the same edge sets `ovf_status[i+1]` and selector bit 63 (overflow mark), and `irq` is high for exactly the following cycle.
- R4: A wrap while `ovf_status[i+1]` is already 1 raises no interrupt and leaves the status bit set.
- R5: Wraps of several counters on the same edge give a single one-cycle `irq` pulse.
- R6: A selector write whose bit 63 is 0 clears `ovf_status[i+1]`. Bit 63 of the written word becomes the stored overflow mark.
- R7: The event code occupies selector bits [EVT_W-1:0]. A written code outside 1..EVT_MAX-1 is stored as 0, and bits 62:EVT_W always read zero.
- R8: Writes with `wr_idx` at or above NUM_CTR change no counter, selector or status bit.
- R9: With `cap_en` low, event pulses change nothing and raise no interrupt.
- R10: A counter write on the same edge as a qualifying event stores the written value, with no increment.
- R11: `rd_cnt` and `rd_sel` present the entry named by `rd_idx` one clock later. An index at or above NUM_CTR reads zero. The selector word is {mark, zeros, code}. `wr_tgt` 0 selects the counter and 1 selects the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Bank present; gates all event counting |
| evt_valid | input | 1 | Event pulse strobe |
| evt_id | input | EVT_W | Event code of the pulse |
| evt_qual | input | NUM_CTR | Per-counter filter qualification |
| inhibit | input | NUM_CTR (bits NUM_CTR:1) | Per-counter inhibit, bit i+1 for counter i |
| wr_en | input | 1 | Software write strobe |
| wr_tgt | input | 1 | 0 = counter, 1 = selector |
| wr_idx | input | 5 | Counter index of the write |
| wr_data | input | CTR_W | Write data |
| rd_idx | input | 5 | Counter index to read |
| rd_cnt | output | CTR_W | Registered counter readback |
| rd_sel | output | CTR_W | Registered selector readback |
| ovf_status | output | NUM_CTR+1 | Overflow status, bit i+1 for counter i, bit 0 zero |
| irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The hard cases are the wraps, because a 64-bit counter never reaches all-ones from counting alone. The stimulus preloads counters to all-ones through the write port, then sends a matching pulse. It does this with the status flag clear, then with it already set, and then for two counters on the same edge, to separate the first-wrap interrupt from the silent repeat and the merged pulse. A directed cycle puts a counter write and a matching event on the same edge. A randomized phase then mixes selector rewrites with illegal codes, inhibit and qualification patterns, and pulses with the bank absent, against a bench model.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  typedef enum logic {
    TGT_CNT = 1'b0,
    TGT_SEL = 1'b1
  } ecb_tgt_e;

  localparam int IDX_W = 5;
endpackage

// File: rtl/ecb_slot.sv
module ecb_slot #(
  parameter int CTR_W   = 64,
  parameter int EVT_W   = 8,
  parameter int EVT_MAX = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en,
  input  logic [EVT_W-1:0] evt_id,
  input  logic             wr_cnt,
  input  logic             wr_sel,
  input  logic [CTR_W-1:0] wr_data,
  input  logic             stat_bit,
  output logic [CTR_W-1:0] cnt_o,
  output logic [CTR_W-1:0] sel_o,
  output logic             wrap_o
);
  localparam int MARK_BIT = CTR_W - 1;
  localparam int PAD_W    = CTR_W - 1 - EVT_W;

  logic [CTR_W-1:0] cnt_q;
  logic [EVT_W-1:0] code_q;
  logic             mark_q;
  logic             hit;
  logic [EVT_W-1:0] code_in;
  logic             code_ok;

  assign hit     = count_en && (code_q != '0) && (code_q == evt_id);
  assign wrap_o  = hit && !wr_cnt && (&cnt_q);
  assign code_in = wr_data[EVT_W-1:0];
  assign code_ok = (code_in != '0) && ({1'b0, code_in} < (EVT_W+1)'(EVT_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wr_data;
    end else if (hit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      mark_q <= 1'b0;
    end else if (wr_sel) begin
      code_q <= code_ok ? code_in : '0;
      mark_q <= wr_data[MARK_BIT];
    end else if (wrap_o && !stat_bit) begin
      mark_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign sel_o = {mark_q, {PAD_W{1'b0}}, code_q};

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !wr_cnt) |=> $stable(cnt_q));
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt_q == $past(wr_data)));
  assert_legal_code_R7: assert property (@(posedge clk) disable iff (rst)
    (code_q == '0) || ({1'b0, code_q} < (EVT_W+1)'(EVT_MAX)));
endmodule

// File: rtl/ecb_rdmux.sv
module ecb_rdmux #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 64,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [CTR_W-1:0] cnt_all [NUM_CTR],
  input  logic [CTR_W-1:0] sel_all [NUM_CTR],
  output logic [CTR_W-1:0] rd_cnt,
  output logic [CTR_W-1:0] rd_sel
);
  logic [CTR_W-1:0] cnt_pick, sel_pick;

  always_comb begin
    cnt_pick = '0;
    sel_pick = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        cnt_pick = cnt_all[i];
        sel_pick = sel_all[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt <= '0;
      rd_sel <= '0;
    end else begin
      rd_cnt <= cnt_pick;
      rd_sel <= sel_pick;
    end
  end

  assert_oor_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_idx >= IDX_W'(NUM_CTR)) |=> (rd_cnt == '0 && rd_sel == '0));
endmodule

// File: rtl/ecb_bank.sv
module ecb_bank
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 64,
  parameter int EVT_W   = 8,
  parameter int EVT_MAX = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_en,
  input  logic               evt_valid,
  input  logic [EVT_W-1:0]   evt_id,
  input  logic [NUM_CTR-1:0] evt_qual,
  input  logic [NUM_CTR:1]   inhibit,
  input  logic               wr_en,
  input  logic               wr_tgt,
  input  logic [4:0]         wr_idx,
  input  logic [CTR_W-1:0]   wr_data,
  input  logic [4:0]         rd_idx,
  output logic [CTR_W-1:0]   rd_cnt,
  output logic [CTR_W-1:0]   rd_sel,
  output logic [NUM_CTR:0]   ovf_status,
  output logic               irq
);
  localparam int MARK_BIT = CTR_W - 1;

  logic [CTR_W-1:0]   cnt_all [NUM_CTR];
  logic [CTR_W-1:0]   sel_all [NUM_CTR];
  logic [NUM_CTR-1:0] wrap_v;
  logic [NUM_CTR-1:0] sel_wr_v;
  logic [NUM_CTR:1]   stat_q;
  logic               irq_q;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
    logic wr_c, wr_s, cen;
    assign wr_c = wr_en && (wr_tgt == TGT_CNT) && (wr_idx == IDX_W'(i));
    assign wr_s = wr_en && (wr_tgt == TGT_SEL) && (wr_idx == IDX_W'(i));
    assign cen  = cap_en && evt_valid && !inhibit[i+1] && evt_qual[i];
    assign sel_wr_v[i] = wr_s;

    ecb_slot #(.CTR_W(CTR_W), .EVT_W(EVT_W), .EVT_MAX(EVT_MAX)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .count_en (cen),
      .evt_id   (evt_id),
      .wr_cnt   (wr_c),
      .wr_sel   (wr_s),
      .wr_data  (wr_data),
      .stat_bit (stat_q[i+1]),
      .cnt_o    (cnt_all[i]),
      .sel_o    (sel_all[i]),
      .wrap_o   (wrap_v[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        stat_q[i+1] <= 1'b0;
      end else if (wrap_v[i]) begin
        stat_q[i+1] <= 1'b1;
      end else if (wr_s && !wr_data[MARK_BIT]) begin
        stat_q[i+1] <= 1'b0;
      end
    end

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
      (sel_wr_v[i] && !wr_data[MARK_BIT] && !wrap_v[i]) |=> !stat_q[i+1]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(wrap_v & ~stat_q);
  end

  ecb_rdmux #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .IDX_W(IDX_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (rd_idx),
    .cnt_all (cnt_all),
    .sel_all (sel_all),
    .rd_cnt  (rd_cnt),
    .rd_sel  (rd_sel)
  );

  assign ovf_status = {stat_q, 1'b0};
  assign irq        = irq_q;

  assert_irq_flag_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> (stat_q != '0));
  assert_absent_R9: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !wr_en) |=> (!irq && $stable(ovf_status)));
  assert_oor_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= 5'(NUM_CTR) && !(cap_en && evt_valid)) |=> $stable(ovf_status));
endmodule

// File: tb/tb_ecb_bank.sv
module tb_ecb_bank;
  localparam int N  = 4;
  localparam int CW = 64;
  localparam int EW = 8;
  localparam int EM = 16;

  logic          clk = 0;
  logic          rst = 1;
  logic          cap_en = 0, evt_valid = 0;
  logic [EW-1:0] evt_id = '0;
  logic [N-1:0]  evt_qual = '0;
  logic [N:1]    inhibit = '0;
  logic          wr_en = 0, wr_tgt = 0;
  logic [4:0]    wr_idx = '0, rd_idx = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] rd_cnt, rd_sel;
  logic [N:0]    ovf_status;
  logic          irq;

  ecb_bank #(.NUM_CTR(N), .CTR_W(CW), .EVT_W(EW), .EVT_MAX(EM)) dut (
    .clk(clk), .rst(rst), .cap_en(cap_en), .evt_valid(evt_valid), .evt_id(evt_id),
    .evt_qual(evt_qual), .inhibit(inhibit), .wr_en(wr_en), .wr_tgt(wr_tgt),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_cnt(rd_cnt),
    .rd_sel(rd_sel), .ovf_status(ovf_status), .irq(irq));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [CW-1:0] m_cnt [N];
  logic [EW-1:0] m_id  [N];
  logic          m_mk  [N];
  logic [N:0]    m_st;

  task automatic chk(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] legal(logic [EW-1:0] c);
    return (c != 0 && c < EM) ? c : '0;
  endfunction

  function automatic logic m_event(logic [EW-1:0] id, logic [N-1:0] q);
    logic fired = 0;
    if (!cap_en) return 0;
    for (int i = 0; i < N; i++) begin
      if (!inhibit[i+1] && q[i] && m_id[i] != 0 && m_id[i] == id) begin
        if (&m_cnt[i]) begin
          m_cnt[i] = '0;
          if (!m_st[i+1]) begin m_st[i+1] = 1; m_mk[i] = 1; fired = 1; end
        end else m_cnt[i] = m_cnt[i] + 1;
      end
    end
    return fired;
  endfunction

  task automatic wr(logic tgt, logic [4:0] idx, logic [CW-1:0] d);
    wr_en = 1; wr_tgt = tgt; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (idx < N) begin
      if (tgt) begin
        m_id[idx] = legal(d[EW-1:0]); m_mk[idx] = d[CW-1];
        if (!d[CW-1]) m_st[idx+1] = 0;
      end else m_cnt[idx] = d;
    end
  endtask

  task automatic ev(string tag, logic [EW-1:0] id, logic [N-1:0] q);
    logic e;
    evt_valid = 1; evt_id = id; evt_qual = q;
    e = m_event(id, q);
    @(negedge clk);
    evt_valid = 0;
    chk({tag, " irq"}, CW'(irq), CW'(e));
  endtask

  task automatic compare_all(string tag);
    for (int i = 0; i < N; i++) begin
      rd_idx = 5'(i);
      @(negedge clk);
      chk({tag, " cnt"}, rd_cnt, m_cnt[i]);
      chk({tag, " sel"}, rd_sel, {m_mk[i], {(CW-1-EW){1'b0}}, m_id[i]});
    end
    chk({tag, " status"}, CW'(ovf_status), CW'(m_st));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [CW-1:0] ones;
    ones = '1;
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_id[i] = 0; m_mk[i] = 0; end
    m_st = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 irq", CW'(irq), 0);
    compare_all("R1 reset");
    cap_en = 1;
    wr(1, 0, 3); wr(1, 1, 3); wr(1, 2, 5); wr(1, 3, 7);
    ev("R2 all qual", 3, 4'b1111);
    ev("R2 qual one", 3, 4'b0001);
    ev("R2 code zero", 0, 4'b1111);
    inhibit[2] = 1;
    ev("R2 inhibit", 3, 4'b1111);
    inhibit = '0;
    compare_all("R2 counts");
    cap_en = 0;
    ev("R9 absent", 3, 4'b1111);
    ev("R9 absent b", 5, 4'b1111);
    cap_en = 1;
    compare_all("R9 unchanged");
    wr(1, 3, 64'h10);
    compare_all("R7 code 16");
    wr(1, 3, 64'h0000_0F00_0000_0005);
    compare_all("R7 pad bits");
    wr(1, 3, 64'hF);
    compare_all("R7 code 15");
    wr(1, 3, 7);
    wr(1, 4, 64'h9); wr(1, 31, 64'h2); wr(0, 5, 64'h55); wr(0, 4, 64'h66);
    compare_all("R8 oor write");
    rd_idx = 4; @(negedge clk);
    chk("R11 oor cnt", rd_cnt, 0);
    chk("R11 oor sel", rd_sel, 0);
    wr(0, 2, ones);
    ev("R3 first wrap", 5, 4'b1111);
    compare_all("R3 wrap state");
    @(negedge clk);
    chk("R3 irq one cycle", CW'(irq), 0);
    wr(0, 2, ones);
    ev("R4 repeat wrap", 5, 4'b1111);
    compare_all("R4 state");
    wr(1, 2, 5);
    compare_all("R6 clear");
    wr(0, 0, ones); wr(0, 1, ones);
    ev("R5 dual wrap", 3, 4'b0011);
    chk("R5 status", CW'(ovf_status), CW'(m_st));
    @(negedge clk);
    chk("R5 single pulse", CW'(irq), 0);
    wr_en = 1; wr_tgt = 0; wr_idx = 3; wr_data = 100;
    evt_valid = 1; evt_id = 7; evt_qual = 4'b1111;
    @(negedge clk);
    wr_en = 0; evt_valid = 0;
    m_cnt[3] = 100;
    compare_all("R10 write wins");
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 9);
      inhibit = N'($urandom);
      cap_en = ($urandom_range(0, 7) != 0);
      if (op == 0) wr(1, 5'($urandom_range(0, 5)), {$urandom_range(0,1) == 1 ? 1'b1 : 1'b0, 55'(0), 8'($urandom_range(0, 20))});
      else if (op == 1) wr(0, 5'($urandom_range(0, 5)), CW'($urandom));
      else ev("R2 random", EW'($urandom_range(0, 8)), N'($urandom));
    end
    cap_en = 1;
    compare_all("R2 random final");
    finish_run();
  end
endmodule